// File: doc/BRIEF.md
# Isochronous Receive Context Control Bank

This block holds the control and status word of four isochronous receive DMA contexts behind a 32-bit register bus. Each context has two byte addresses. A write to the first ORs the written ones into the control word. A write to the second removes the written ones from it. A read at either address returns the live word. Only the bits named in the requirements are stored. Every other bit reads as zero.

The bank guards its own configuration. While a context is running or active, the packing, header and match-enable bits cannot be changed by software. A write that would turn on multi-channel mode without buffer packing is dropped for that context as a whole. A context can also start on a cycle boundary. With match-enable and run both on, the context waits for a cycle-start event whose 13-bit count equals the value held in bits 24..12 of that context's match word. When that event arrives, active goes high and match-enable is cleared by hardware at the same clock edge.

The register bus is a plain strobe interface, not a stream. Writes complete at the clock edge that samples `bus_wr`. Reads are combinational and cannot be stalled, so there is no back-pressure. The cycle-start event is a one-cycle `cs_valid` pulse with no ready signal, and all four contexts evaluate it in parallel.

Top module: `isorx_ctl_bank`

## Requirements
- R1: Context n (0..3) is written through its set address 0x400+32*n and its clear address 0x404+32*n. A read at either address returns the word {bit31 buffer-pack, bit30 keep-header, bit29 match-enable, bit28 multi-channel, bit15 run, bit10 active}, and every other bit reads as 0.
- R2: A write to a set address sets, at the next clock edge, every writable bit (31, 30, 29, 28, 15) whose data bit is 1. It leaves the other bits unchanged.
- R3: A write to a clear address clears, at the next clock edge, every writable bit whose data bit is 1. It leaves the other bits unchanged.
- R4: While run or active is 1 before the write, a write cannot change bits 31, 30 or 29. Bits 28 and 15 still follow the write.
- R5: If a write would leave multi-channel at 1 with buffer-pack at 0, that context drops the whole write and its word is unchanged.
- R6: If run is 1 after a write and match-enable is 0, active becomes 1 at that same clock edge. If run becomes 0, active becomes 0 at that same edge.
- R7: With run and match-enable at 1 and active at 0, a `cs_valid` pulse whose `cs_count` equals bits 24..12 of the context's match word sets active and clears match-enable at the same clock edge.
- R8: A cycle-start event with a count that does not match, or one that arrives while run is 0, leaves active and match-enable unchanged.
- R9: After reset every context reads 0.
- R10: Writes to a byte address that is not a set or clear address change no context, and reads there return 0.
- R11: If one write sets run and match-enable while a matching event arrives in the same cycle, the hardware clear wins: the result is active 1, match-enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data at `bus_addr` |
| match_regs | input | 128 | Match word of each context, 32 bits per context; bits 24..12 of each word hold the cycle value |
| cs_valid | input | 1 | One-cycle pulse marking a cycle-start event |
| cs_count | input | 13 | Cycle count carried by the event |

## Verification
Every stored result is due one clock edge after its stimulus. That covers set and clear writes, lock-out, rejection, run-driven activation and a cycle-match start. A read returns data in the same cycle its address is presented. The bench therefore drives a write or event just after a falling edge and lets exactly one rising edge pass. It removes the stimulus at the next falling edge and then reads all four contexts and one unmapped address combinationally. Each read is compared with a model that was advanced by one step for that same edge.

// File: rtl/isorx_pkg.sv
package isorx_pkg;
  localparam int BIT_PACK  = 31;
  localparam int BIT_HDR   = 30;
  localparam int BIT_MEN   = 29;
  localparam int BIT_MULTI = 28;
  localparam int BIT_RUN   = 15;
  localparam int BIT_ACT   = 10;
  localparam int CYC_W     = 13;
  localparam int CYC_LSB   = 12;

  typedef struct packed {
    logic pack;
    logic hdr;
    logic men;
    logic multi;
    logic run;
    logic act;
  } ctx_word_t;

  function automatic logic [31:0] to_bus(ctx_word_t c);
    logic [31:0] v;
    v = '0;
    v[BIT_PACK]  = c.pack;
    v[BIT_HDR]   = c.hdr;
    v[BIT_MEN]   = c.men;
    v[BIT_MULTI] = c.multi;
    v[BIT_RUN]   = c.run;
    v[BIT_ACT]   = c.act;
    return v;
  endfunction
endpackage

// File: rtl/isorx_addr_dec.sv
module isorx_addr_dec #(
  parameter int NCTX   = 4,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h400,
  parameter int STRIDE = 32,
  parameter int CLR_OFS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NCTX-1:0]   sel_set,
  output logic [NCTX-1:0]   sel_clr
);
  for (genvar i = 0; i < NCTX; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE + STRIDE * i);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE + STRIDE * i + CLR_OFS);
    assign sel_set[i] = (addr == SET_A);
    assign sel_clr[i] = (addr == CLR_A);
  end
endmodule

// File: rtl/isorx_ctx.sv
module isorx_ctx
  import isorx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [31:0]      wdata,
  input  logic             cs_valid,
  input  logic [CYC_W-1:0] cs_count,
  input  logic [CYC_W-1:0] match_val,
  output ctx_word_t        word
);
  ctx_word_t q, merged, nxt;
  logic      locked, reject, hit;
  logic      unused_wd;

  assign unused_wd = ^{wdata[27:16], wdata[14:0]};
  assign locked    = q.run | q.act;

  always_comb begin
    merged = q;
    if (wr_set) begin
      merged.pack  = q.pack  | wdata[BIT_PACK];
      merged.hdr   = q.hdr   | wdata[BIT_HDR];
      merged.men   = q.men   | wdata[BIT_MEN];
      merged.multi = q.multi | wdata[BIT_MULTI];
      merged.run   = q.run   | wdata[BIT_RUN];
    end else if (wr_clr) begin
      merged.pack  = q.pack  & ~wdata[BIT_PACK];
      merged.hdr   = q.hdr   & ~wdata[BIT_HDR];
      merged.men   = q.men   & ~wdata[BIT_MEN];
      merged.multi = q.multi & ~wdata[BIT_MULTI];
      merged.run   = q.run   & ~wdata[BIT_RUN];
    end
    if (locked) begin
      merged.pack = q.pack;
      merged.hdr  = q.hdr;
      merged.men  = q.men;
    end
    reject = merged.multi & ~merged.pack;
    if (reject) merged = q;
  end

  assign hit = cs_valid & merged.men & (cs_count == match_val);

  always_comb begin
    nxt     = merged;
    nxt.act = merged.run & (q.act | ~merged.men | hit);
    if (merged.run & ~q.act & hit) nxt.men = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign word = q;

  // R4: configuration bits hold while the context is locked
  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q.run | q.act) |=> $stable({q.pack, q.hdr}));
  // R5: multi-channel never stands without buffer packing
  p_multi_needs_pack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q.multi |-> q.pack);
  // R6: no active context without run
  p_act_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !q.run |-> !q.act);
  // R6: run rising with match-enable off starts at once
  p_run_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(q.run) && !q.men) |-> q.act);
  // R7: becoming active always leaves match-enable cleared
  p_men_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q.act) |-> !q.men);
endmodule

// File: rtl/isorx_ctl_bank.sv
module isorx_ctl_bank
  import isorx_pkg::*;
#(
  parameter int NCTX   = 4,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h400,
  parameter int STRIDE = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NCTX*32-1:0]   match_regs,
  input  logic                 cs_valid,
  input  logic [CYC_W-1:0]     cs_count
);
  logic [NCTX-1:0] sel_set, sel_clr;
  ctx_word_t       words [NCTX];
  logic [31:0]     rd_terms [NCTX];
  logic            unused_match;

  assign unused_match = ^match_regs;

  isorx_addr_dec #(
    .NCTX(NCTX), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE), .CLR_OFS(4)
  ) u_dec (
    .addr(bus_addr), .sel_set(sel_set), .sel_clr(sel_clr)
  );

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    isorx_ctx u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_set    (bus_wr & sel_set[i]),
      .wr_clr    (bus_wr & sel_clr[i]),
      .wdata     (bus_wdata),
      .cs_valid  (cs_valid),
      .cs_count  (cs_count),
      .match_val (match_regs[i*32+CYC_LSB +: CYC_W]),
      .word      (words[i])
    );
    assign rd_terms[i] = (sel_set[i] | sel_clr[i]) ? to_bus(words[i]) : '0;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCTX; i++) bus_rdata = bus_rdata | rd_terms[i];
  end

  // R10: unmapped addresses read zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|{sel_set, sel_clr}) |-> (bus_rdata == '0));
  // R1: at most one register selected
  p_single_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_set, sel_clr}));
endmodule

// File: tb/isorx_ctl_bank_tb.sv
module isorx_ctl_bank_tb;
  localparam int N = 4;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [127:0] match_regs = '0;
  logic        cs_valid = 0;
  logic [12:0] cs_count = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  logic m_pack[N], m_hdr[N], m_men[N], m_multi[N], m_run[N], m_act[N];

  always #10 clk = ~clk;

  isorx_ctl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .match_regs(match_regs),
    .cs_valid(cs_valid), .cs_count(cs_count)
  );

  function automatic logic [31:0] exp_word(int i);
    logic [31:0] v = '0;
    v[31] = m_pack[i]; v[30] = m_hdr[i]; v[29] = m_men[i];
    v[28] = m_multi[i]; v[15] = m_run[i]; v[10] = m_act[i];
    return v;
  endfunction

  function automatic logic [12:0] match_of(int i);
    return match_regs[i*32+12 +: 13];
  endfunction

  task automatic model_step(bit wr, logic [11:0] a, logic [31:0] d, bit cv, logic [12:0] cc);
    for (int i = 0; i < N; i++) begin
      bit s = wr && (a == 12'(32'h400 + 32*i));
      bit c = wr && (a == 12'(32'h404 + 32*i));
      bit lk = m_run[i] | m_act[i];
      logic p = m_pack[i], h = m_hdr[i], e = m_men[i], mu = m_multi[i], r = m_run[i];
      bit hit;
      if (s) begin p |= d[31]; h |= d[30]; e |= d[29]; mu |= d[28]; r |= d[15]; end
      if (c) begin p &= ~d[31]; h &= ~d[30]; e &= ~d[29]; mu &= ~d[28]; r &= ~d[15]; end
      if (lk) begin p = m_pack[i]; h = m_hdr[i]; e = m_men[i]; end
      if (mu && !p) begin p = m_pack[i]; h = m_hdr[i]; e = m_men[i]; mu = m_multi[i]; r = m_run[i]; end
      hit = cv && e && (cc == match_of(i));
      if (r && !m_act[i] && hit) e = 0;
      m_act[i] = r && (m_act[i] || !m_men_pre(e, hit) || hit);
      m_pack[i] = p; m_hdr[i] = h; m_men[i] = e; m_multi[i] = mu; m_run[i] = r;
    end
  endtask

  // match-enable value before a hardware clear
  function automatic bit m_men_pre(logic e_after, bit hit);
    return e_after | hit;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < N; i++) begin
      bus_addr = 12'(32'h400 + 32*i + (i % 2) * 4); #1;
      check(req, bus_rdata, exp_word(i));
    end
    bus_addr = 12'h408; #1;
    check("R10", bus_rdata, 32'h0);
  endtask

  task automatic op(string req, bit wr, logic [11:0] a, logic [31:0] d, bit cv, logic [12:0] cc);
    bus_wr = wr; bus_addr = a; bus_wdata = d; cs_valid = cv; cs_count = cc;
    model_step(wr, a, d, cv, cc);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; cs_valid = 0;
    read_all(req);
  endtask

  function automatic logic [11:0] set_a(int i); return 12'(32'h400 + 32*i); endfunction
  function automatic logic [11:0] clr_a(int i); return 12'(32'h404 + 32*i); endfunction

  initial begin
    #3000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] dd;
    int unsigned r;
    r = $urandom(32'd20240517);
    for (int i = 0; i < N; i++) begin
      m_pack[i] = 0; m_hdr[i] = 0; m_men[i] = 0; m_multi[i] = 0; m_run[i] = 0; m_act[i] = 0;
      match_regs[i*32 +: 32] = $urandom;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    read_all("R9");

    // R2: set packing/header/multi on context 0
    op("R2", 1, set_a(0), 32'hD000_0000, 0, 0);
    // R3: clear header only
    op("R3", 1, clr_a(0), 32'h4000_0000, 0, 0);
    // R5: multi without packing on context 2 is dropped
    op("R5", 1, set_a(2), 32'h1000_8000, 0, 0);
    // R6: run with match-enable off starts context 1
    op("R6", 1, set_a(1), 32'h0000_8000, 0, 0);
    // R4: locked bits on running context 1 stay put
    op("R4", 1, set_a(1), 32'hE000_0000, 0, 0);
    // R6: clearing run stops at once
    op("R6", 1, clr_a(1), 32'h0000_8000, 0, 0);
    // R10: unmapped write
    op("R10", 1, 12'h408, 32'hFFFF_FFFF, 0, 0);
    op("R10", 1, 12'h480, 32'hFFFF_FFFF, 0, 0);
    // R7: arm context 3, wrong count, then matching count
    op("R7", 1, set_a(3), 32'h2000_8000, 0, 0);
    op("R8", 0, 12'h0, 0, 1, match_of(3) + 13'd1);
    op("R7", 0, 12'h0, 0, 1, match_of(3));
    // R8: event with run off does nothing
    op("R8", 1, set_a(2), 32'h2000_0000, 0, 0);
    op("R8", 0, 12'h0, 0, 1, match_of(2));
    // R11: arm and match in same cycle on context 2
    op("R11", 1, set_a(2), 32'h2000_8000, 1, match_of(2));
    // R1: bits outside the map are ignored
    op("R1", 1, set_a(0), 32'h0FFF_7BFF, 0, 0);

    for (int k = 0; k < 400; k++) begin
      int i = $urandom_range(N-1);
      logic [11:0] a;
      bit cv;
      logic [12:0] cc;
      case ($urandom_range(9))
        0: a = 12'($urandom_range(4095));
        1, 2, 3, 4: a = set_a(i);
        default: a = clr_a(i);
      endcase
      dd = $urandom & 32'hF000_8000;
      cv = ($urandom_range(2) == 0);
      cc = ($urandom_range(1) == 0) ? match_of($urandom_range(N-1)) : 13'($urandom);
      op("R2", ($urandom_range(3) != 0), a, dd, cv, cc);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule